// File: doc/BRIEF.md
# Dual-Domain Supply Lockout Supervisor

This block turns the comparator flags of two supply domains into a single enable for a power-switch gate driver. One domain watches the control-side supply and the other watches the switch-side supply. Each domain gets two flags that have already been synchronised. One says the supply is above the turn-on level. The other says it is below the lower turn-off level. The gap between the two levels gives the domain hysteresis.

Each domain holds a healthy bit. A change of that bit must be backed by its flag for an unbroken run of clock cycles. The run length has its own parameter for each domain and each direction. When the flag drops before the run completes, the count starts again from zero. A supply dip shorter than the fall window therefore never reaches the enable. The combined enable is high only while both domains are healthy.

Top module: `uv_supervisor`

## Requirements
- R1: During and right after reset, `ctl_ok`, `pwr_ok` and `drv_en` are all 0.
- R2: An unhealthy control-side domain becomes healthy only after `ctl_above_on` has been 1 for CTL_RISE_CYC consecutive sampling edges. `ctl_ok` goes to 1 on the last of those edges.
- R3: A healthy control-side domain becomes unhealthy only after `ctl_below_off` has been 1 for CTL_FALL_CYC consecutive sampling edges. `ctl_ok` goes to 0 on the last of those edges.
- R4: An unhealthy switch-side domain becomes healthy only after `pwr_above_on` has been 1 for PWR_RISE_CYC consecutive edges.
- R5: A healthy switch-side domain becomes unhealthy only after `pwr_below_off` has been 1 for PWR_FALL_CYC consecutive edges.
- R6: A below-off dip shorter than the fall window of its domain leaves that domain's healthy flag and `drv_en` at 1.
- R7: Between the thresholds (both flags 0), a domain keeps its present healthy state for any length of time. A healthy domain ignores `above_on`, and an unhealthy domain ignores `below_off`.
- R8: `drv_en` is 1 only while both `ctl_ok` and `pwr_ok` are 1. It drops in the same cycle that either domain is declared unhealthy.
- R9: If the qualifying flag drops for a single edge before a window completes, the count restarts, and a full new window is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_above_on | input | 1 | Control-side supply above turn-on level |
| ctl_below_off | input | 1 | Control-side supply below turn-off level |
| pwr_above_on | input | 1 | Switch-side supply above turn-on level |
| pwr_below_off | input | 1 | Switch-side supply below turn-off level |
| ctl_ok | output | 1 | Control-side domain qualified healthy |
| pwr_ok | output | 1 | Switch-side domain qualified healthy |
| drv_en | output | 1 | Driver enable, both domains healthy |

## Verification
A window counter that is off by one shows up at the ports as a healthy flag that moves one edge early or late. The bench checks both the edge before the expected change and the edge on which it should happen. A counter that fails to clear on an interrupted flag shows up in the dip sweeps as a spurious drop or rise, within one window of the interruption. A wrong hysteresis state selects the wrong flag, which is visible after the first between-threshold cycle.

// File: rtl/uvs_pkg.sv
package uvs_pkg;
   localparam int unsigned UVS_DOMAINS = 2;

   function automatic int unsigned uvs_cnt_w(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

   function automatic int unsigned uvs_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/uvs_qual_timer.sv
module uvs_qual_timer #(
   parameter int unsigned MAX_CYC = 8,
   parameter int unsigned CW      = uvs_pkg::uvs_cnt_w(MAX_CYC)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cond,
   input  logic [CW-1:0] limit,
   output logic          done
);
   generate
      if (MAX_CYC < 1) begin : g_bad
         $error("uvs_qual_timer: MAX_CYC must be at least 1");
      end
      if (MAX_CYC == 1) begin : g_direct
         logic unused_lim;
         assign unused_lim = ^limit;
         assign done = cond;
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         assign done = cond && (cnt_q == limit);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (!cond || done)
               cnt_q <= '0;
            else
               cnt_q <= cnt_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/uvs_domain.sv
module uvs_domain #(
   parameter int unsigned RISE_CYC = 4,
   parameter int unsigned FALL_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic above_on,
   input  logic below_off,
   output logic healthy
);
   localparam int unsigned MAXC = uvs_pkg::uvs_max(RISE_CYC, FALL_CYC);
   localparam int unsigned CW   = uvs_pkg::uvs_cnt_w(MAXC);
   localparam logic [CW-1:0] RISE_LIM = CW'(RISE_CYC - 1);
   localparam logic [CW-1:0] FALL_LIM = CW'(FALL_CYC - 1);

   generate
      if (RISE_CYC < 1 || FALL_CYC < 1) begin : g_bad
         $error("uvs_domain: delays must be at least one cycle");
      end
   endgenerate

   logic          state_q;
   logic          watch;
   logic [CW-1:0] lim;
   logic          flip;

   always_comb begin
      watch = state_q ? below_off : above_on;
      lim   = state_q ? FALL_LIM  : RISE_LIM;
   end

   uvs_qual_timer #(.MAX_CYC(MAXC), .CW(CW)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .cond  (watch),
      .limit (lim),
      .done  (flip)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_q <= 1'b0;
      else if (flip)
         state_q <= ~state_q;
   end

   assign healthy = state_q;
endmodule

// File: rtl/uv_supervisor.sv
module uv_supervisor #(
   parameter int unsigned CTL_RISE_CYC = 77,
   parameter int unsigned CTL_FALL_CYC = 150,
   parameter int unsigned PWR_RISE_CYC = 100,
   parameter int unsigned PWR_FALL_CYC = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ctl_above_on,
   input  logic ctl_below_off,
   input  logic pwr_above_on,
   input  logic pwr_below_off,
   output logic ctl_ok,
   output logic pwr_ok,
   output logic drv_en
);
   localparam int unsigned ND = uvs_pkg::UVS_DOMAINS;

   logic [ND-1:0] hi_flag;
   logic [ND-1:0] lo_flag;
   logic [ND-1:0] dom_ok;

   assign hi_flag = {pwr_above_on,  ctl_above_on};
   assign lo_flag = {pwr_below_off, ctl_below_off};

   generate
      for (genvar d = 0; d < ND; d++) begin : g_dom
         localparam int unsigned RC = (d == 0) ? CTL_RISE_CYC : PWR_RISE_CYC;
         localparam int unsigned FC = (d == 0) ? CTL_FALL_CYC : PWR_FALL_CYC;
         uvs_domain #(.RISE_CYC(RC), .FALL_CYC(FC)) u_dom (
            .clk       (clk),
            .rst_n     (rst_n),
            .above_on  (hi_flag[d]),
            .below_off (lo_flag[d]),
            .healthy   (dom_ok[d])
         );
      end
   endgenerate

   assign ctl_ok = dom_ok[0];
   assign pwr_ok = dom_ok[1];
   assign drv_en = &dom_ok;
endmodule

// File: rtl/uv_supervisor_chk.sv
module uv_supervisor_chk (
   input logic clk,
   input logic rst_n,
   input logic ctl_above_on,
   input logic ctl_below_off,
   input logic pwr_above_on,
   input logic pwr_below_off,
   input logic ctl_ok,
   input logic pwr_ok,
   input logic drv_en
);
   // R1
   reset_low_chk: assert property (@(posedge clk) !rst_n |=> (!ctl_ok && !pwr_ok && !drv_en));
   // R2
   ctl_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(ctl_ok) |-> $past(ctl_above_on));
   // R3
   ctl_fall_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(ctl_ok) |-> $past(ctl_below_off));
   // R4
   pwr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(pwr_ok) |-> $past(pwr_above_on));
   // R5
   pwr_fall_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(pwr_ok) |-> $past(pwr_below_off));
   // R7
   ctl_hold_up_chk: assert property (@(posedge clk) disable iff (!rst_n) (ctl_ok && !ctl_below_off) |=> ctl_ok);
   // R7
   ctl_hold_dn_chk: assert property (@(posedge clk) disable iff (!rst_n) (!ctl_ok && !ctl_above_on) |=> !ctl_ok);
   // R7
   pwr_hold_up_chk: assert property (@(posedge clk) disable iff (!rst_n) (pwr_ok && !pwr_below_off) |=> pwr_ok);
   // R8
   en_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n) drv_en |-> (ctl_ok && pwr_ok));
endmodule

bind uv_supervisor uv_supervisor_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .ctl_above_on  (ctl_above_on),
   .ctl_below_off (ctl_below_off),
   .pwr_above_on  (pwr_above_on),
   .pwr_below_off (pwr_below_off),
   .ctl_ok        (ctl_ok),
   .pwr_ok        (pwr_ok),
   .drv_en        (drv_en)
);

// File: tb/uv_supervisor_bench.sv
`timescale 1ns/1ps
module uv_supervisor_bench;
   localparam int IR = 5;
   localparam int IF = 8;
   localparam int OR = 6;
   localparam int OF = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ca = 1'b0, cb = 1'b1, pa = 1'b0, pb = 1'b1;
   logic ctl_ok, pwr_ok, drv_en;
   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   uv_supervisor #(.CTL_RISE_CYC(IR), .CTL_FALL_CYC(IF),
                   .PWR_RISE_CYC(OR), .PWR_FALL_CYC(OF)) u_uv_supervisor (
      .clk(clk), .rst_n(rst_n),
      .ctl_above_on(ca), .ctl_below_off(cb),
      .pwr_above_on(pa), .pwr_below_off(pb),
      .ctl_ok(ctl_ok), .pwr_ok(pwr_ok), .drv_en(drv_en));

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(4 * 20000);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   initial begin
      tick(3);
      chk("R1 ctl_ok", ctl_ok, 1'b0);
      chk("R1 drv_en", drv_en, 1'b0);
      rst_n = 1'b1;
      tick(1);
      chk("R1 pwr_ok", pwr_ok, 1'b0);
      // R9: interrupted control-side rise windows, between thresholds
      cb = 1'b0;
      for (int l = 1; l < IR; l++) begin
         ca = 1'b1; tick(l);
         chk("R9 ctl partial", ctl_ok, 1'b0);
         ca = 1'b0; tick(1);
         chk("R9 ctl gap", ctl_ok, 1'b0);
      end
      // R7: unhealthy ignores below_off low for a long time
      tick(20);
      chk("R7 ctl stays down", ctl_ok, 1'b0);
      // R2
      ca = 1'b1; tick(IR - 1);
      chk("R2 ctl early", ctl_ok, 1'b0);
      tick(1);
      chk("R2 ctl on", ctl_ok, 1'b1);
      chk("R8 only ctl", drv_en, 1'b0);
      // R9 on switch side, then R4
      pb = 1'b0;
      for (int l = 1; l < OR; l++) begin
         pa = 1'b1; tick(l);
         chk("R9 pwr partial", pwr_ok, 1'b0);
         pa = 1'b0; tick(1);
      end
      pa = 1'b1; tick(OR - 1);
      chk("R4 pwr early", pwr_ok, 1'b0);
      tick(1);
      chk("R4 pwr on", pwr_ok, 1'b1);
      chk("R8 both", drv_en, 1'b1);
      // R7: healthy ignores above_on low
      ca = 1'b0; pa = 1'b0; tick(25);
      chk("R7 ctl hold", ctl_ok, 1'b1);
      chk("R7 pwr hold", pwr_ok, 1'b1);
      // R6: control-side dips of every short length
      for (int d = 1; d < IF; d++) begin
         cb = 1'b1; tick(d);
         chk("R6 ctl dip", ctl_ok, 1'b1);
         chk("R6 en dip", drv_en, 1'b1);
         cb = 1'b0; tick(1);
      end
      // R3
      cb = 1'b1; tick(IF - 1);
      chk("R3 ctl early", ctl_ok, 1'b1);
      tick(1);
      chk("R3 ctl off", ctl_ok, 1'b0);
      chk("R8 ctl drop", drv_en, 1'b0);
      chk("R8 pwr kept", pwr_ok, 1'b1);
      // recover control side
      cb = 1'b0; ca = 1'b1; tick(IR);
      chk("R2 ctl back", ctl_ok, 1'b1);
      chk("R8 back", drv_en, 1'b1);
      // R6 on switch side
      for (int d = 1; d < OF; d++) begin
         pb = 1'b1; tick(d);
         chk("R6 pwr dip", pwr_ok, 1'b1);
         pb = 1'b0; tick(1);
      end
      // R5
      pb = 1'b1; tick(OF - 1);
      chk("R5 pwr early", pwr_ok, 1'b1);
      tick(1);
      chk("R5 pwr off", pwr_ok, 1'b0);
      chk("R8 pwr drop", drv_en, 1'b0);
      // R1 again: reset mid-operation
      rst_n = 1'b0; tick(1);
      chk("R1 re-reset ctl", ctl_ok, 1'b0);
      finish_run();
   end
endmodule